// File: doc/BRIEF.md
# Fuse array command controller

This block sits between a simple zero-wait register bus and a one-time-programmable fuse array of `WORDS` words of `WIDTH` bits. Software loads timing values and the data it wants to burn, writes an unlock key, and then writes an opcode to the command register. The controller sequences the operation and clears the command register once it is done. Software learns that the operation has finished either by polling that register or from an interrupt.

A read scans every fuse word in turn and copies it into a read-only shadow register. A program first takes a snapshot of the array. It then walks every bit position and burns only those bits that are requested, still unblown and not protected by a lock bit. Finally it rescans the array so that the shadows hold the new contents. Word 0 holds the lock bits: bit k of word 0 protects word k, and bit 0 protects word 0 itself. Because locks are taken from the snapshot, a lock bit and the data it guards can be burned in the same operation. Read-done and program-done events are latched in a raw interrupt register. That register is masked by an enable register, and the masked result drives one interrupt line.

Top module: `fuse_cmd_ctrl`

## Requirements
- R1: A command write takes effect only when the opcode and key match. Opcode 1 written to the command register (offset 0x04) starts a read only while the key register (offset 0x00) holds 0x5AA5. Opcode 2 starts a program only while the key holds 0x5A5A. Any other opcode/key pair is ignored: the command register reads 0 and no strobe toggles.
- R2: While an operation runs, the command register reads its opcode (1 or 2). It reads 0 from the cycle after the final word capture.
- R3: A read holds the read strobe on each word, in ascending order, for `max(1, RD)` cycles. RD is bits [7:0] of the timing register at offset 0x18. The read lasts exactly `WORDS*max(1,RD)` cycles, and afterwards shadow word i (offset 0x40+4i) equals fuse word i.
- R4: A program burns only bits whose program-data bit (offset 0x80+4i) is 1 and whose fuse is still 0. No burn pulse ever starts on a fuse that is already blown.
- R5: Bit k of fuse word 0, as it stood when the program began, blocks every burn in word k. A lock bit burned in the same operation does not block its word until the next program.
- R6: Each burn pulse lasts `max(1,PG)*max(1,DIV)` cycles. PG is bits [15:8] of offset 0x18 and DIV is bits [7:0] of offset 0x1C. A skipped bit position costs one cycle. A whole program lasts `2*WORDS*max(1,RD) + WORDS*WIDTH - n + n*pulse` cycles, where n is the number of bits burned.
- R7: When a program completes, the shadow registers hold the array contents after the burns.
- R8: When a read completes, bit 0 of the raw interrupt register (offset 0x08) is set. When a program completes, bit 1 is set.
- R9: Writing 1 to a bit of the clear register (offset 0x14) clears that raw bit. If a clear lands on the completion cycle of the matching event, the set takes priority.
- R10: The status register (offset 0x10) reads raw AND enable, where the enable register is at offset 0x0C. The interrupt output is high exactly when any status bit is set.
- R11: A command write that arrives while an operation is running changes nothing, and it does not start a second operation.
- R12: After reset, the following hold: the command, raw, enable, key, shadow and program-data registers read 0; the timing register reads 0x8050; the divider reads 100 (0x64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write access |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq | output | 1 | Interrupt line |
| fuse_addr | output | $clog2(WORDS) | Word being read or burned |
| fuse_bit | output | $clog2(WIDTH) | Bit being burned |
| fuse_rd | output | 1 | Read strobe |
| fuse_rdata | input | WIDTH | Word contents of the array at fuse_addr |
| fuse_burn | output | 1 | Burn strobe |

## Verification
The bench sweeps read-strobe lengths 0, 1 and 3 against burn factors 0 and 2 and divider values 1 and 3. This separates the zero-means-one rule from plain lengths, and a product from a sum. At every setting it issues a read and then a program over pseudo-random fuse contents, lock words and program data. The exact operation length, the count of strobe cycles and the final array tell apart a missing skip of blown bits, a missing lock, or a wrong pulse size. Directed cases try every wrong key/opcode pairing, a command sent while busy, a lock burned together with its data, a clear that collides with completion, and all four enable masks.

// File: rtl/fuse_cmd_ctrl.sv
module fuse_cmd_ctrl #(
  parameter int WORDS = 4,
  parameter int WIDTH = 16,
  parameter logic [15:0] READ_KEY = 16'h5AA5,
  parameter logic [15:0] PROG_KEY = 16'h5A5A,
  parameter logic [7:0] RST_RD = 8'd80,
  parameter logic [7:0] RST_PG = 8'd128,
  parameter logic [7:0] RST_DIV = 8'd100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic psel,
  input  logic penable,
  input  logic pwrite,
  input  logic [7:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic irq,
  output logic [$clog2(WORDS)-1:0] fuse_addr,
  output logic [$clog2(WIDTH)-1:0] fuse_bit,
  output logic fuse_rd,
  input  logic [WIDTH-1:0] fuse_rdata,
  output logic fuse_burn
);
  localparam int WA = $clog2(WORDS);
  localparam int WB = $clog2(WIDTH);
  localparam int BW = WA + WB;
  localparam int NBITS = WORDS * WIDTH;
  localparam logic [5:0] A_KEY = 6'd0, A_CMD = 6'd1, A_RAW = 6'd2, A_ENA = 6'd3,
                         A_ST = 6'd4, A_CLR = 6'd5, A_TIM = 6'd6, A_DIV = 6'd7;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_PRE = 2'd1, S_BURN = 2'd2, S_SCAN = 2'd3} st_t;

  st_t st;
  logic [1:0] cmd, raw, ena;
  logic [15:0] key;
  logic [7:0] t_rd, t_pg, t_div;
  logic [WIDTH-1:0] shadow [WORDS];
  logic [WIDTH-1:0] snap [WORDS];
  logic [WIDTH-1:0] pgm [WORDS];
  logic [WA-1:0] widx;
  logic [BW-1:0] bidx;
  logic [15:0] cnt;

  wire [5:0] wa = paddr[7:2];
  wire unused_addr_lsb = &{1'b0, paddr[1:0]};
  wire wr = psel & penable & pwrite;
  wire [WA-1:0] slot = wa[WA-1:0];
  wire sh_hit = (wa[5:4] == 2'b01) && (int'(wa[3:0]) < WORDS);
  wire pg_hit = (wa[5:4] == 2'b10) && (int'(wa[3:0]) < WORDS);

  wire [7:0] pg1 = (t_pg == 8'd0) ? 8'd1 : t_pg;
  wire [7:0] div1 = (t_div == 8'd0) ? 8'd1 : t_div;
  wire [15:0] rd_len = (t_rd == 8'd0) ? 16'd1 : {8'd0, t_rd};
  wire [15:0] burn_len = {8'd0, pg1} * {8'd0, div1};

  wire [WA-1:0] bw = bidx[BW-1:WB];
  wire [WB-1:0] bb = bidx[WB-1:0];
  wire want = pgm[bw][bb] & ~snap[bw][bb] & ~snap[0][bw];

  wire scanning = (st == S_PRE) || (st == S_SCAN);
  wire rd_last = scanning && (cnt == rd_len - 16'd1);
  wire word_last = (widx == WA'(WORDS - 1));
  wire bit_step = (st == S_BURN) && (!want || cnt == burn_len - 16'd1);
  wire bit_last = (bidx == BW'(NBITS - 1));
  wire finish = (st == S_SCAN) && rd_last && word_last;

  wire cmd_wr = wr && (wa == A_CMD) && (st == S_IDLE);
  wire go_rd = cmd_wr && (pwdata == 32'd1) && (key == READ_KEY);
  wire go_pg = cmd_wr && (pwdata == 32'd2) && (key == PROG_KEY);
  wire [1:0] clr = (wr && wa == A_CLR) ? pwdata[1:0] : 2'b00;
  wire [1:0] set = {finish && cmd == 2'd2, finish && cmd == 2'd1};

  assign fuse_rd = scanning;
  assign fuse_burn = (st == S_BURN) && want;
  assign fuse_addr = (st == S_BURN) ? bw : widx;
  assign fuse_bit = bb;
  assign irq = |(raw & ena);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd <= 2'd0;
      cnt <= 16'd0;
      widx <= '0;
      bidx <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= 16'd0;
          widx <= '0;
          bidx <= '0;
          if (go_rd) begin
            st <= S_SCAN;
            cmd <= 2'd1;
          end else if (go_pg) begin
            st <= S_PRE;
            cmd <= 2'd2;
          end
        end
        S_PRE, S_SCAN: begin
          if (rd_last) begin
            cnt <= 16'd0;
            widx <= widx + 1'b1;
            if (word_last) begin
              widx <= '0;
              if (st == S_PRE) st <= S_BURN;
              else begin
                st <= S_IDLE;
                cmd <= 2'd0;
              end
            end
          end else cnt <= cnt + 16'd1;
        end
        S_BURN: begin
          if (bit_step) begin
            cnt <= 16'd0;
            bidx <= bidx + 1'b1;
            if (bit_last) begin
              bidx <= '0;
              st <= S_SCAN;
            end
          end else cnt <= cnt + 16'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        shadow[i] <= '0;
        snap[i] <= '0;
      end
    end else if (rd_last) begin
      if (st == S_PRE) snap[widx] <= fuse_rdata;
      else shadow[widx] <= fuse_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key <= 16'd0;
      ena <= 2'd0;
      raw <= 2'd0;
      t_rd <= RST_RD;
      t_pg <= RST_PG;
      t_div <= RST_DIV;
      for (int i = 0; i < WORDS; i++) pgm[i] <= '0;
    end else begin
      raw <= (raw & ~clr) | set;
      if (wr) begin
        if (pg_hit) pgm[slot] <= pwdata[WIDTH-1:0];
        case (wa)
          A_KEY: key <= pwdata[15:0];
          A_ENA: ena <= pwdata[1:0];
          A_TIM: begin
            t_rd <= pwdata[7:0];
            t_pg <= pwdata[15:8];
          end
          A_DIV: t_div <= pwdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = 32'd0;
    if (sh_hit) prdata[WIDTH-1:0] = shadow[slot];
    else if (pg_hit) prdata[WIDTH-1:0] = pgm[slot];
    else begin
      case (wa)
        A_KEY: prdata[15:0] = key;
        A_CMD: prdata[1:0] = cmd;
        A_RAW: prdata[1:0] = raw;
        A_ENA: prdata[1:0] = ena;
        A_ST:  prdata[1:0] = raw & ena;
        A_TIM: prdata[15:0] = {t_pg, t_rd};
        A_DIV: prdata[7:0] = t_div;
        default: prdata = 32'd0;
      endcase
    end
  end
endmodule

module fuse_cmd_ctrl_sva #(
  parameter logic [15:0] READ_KEY = 16'h5AA5,
  parameter logic [15:0] PROG_KEY = 16'h5A5A
) (
  input logic clk,
  input logic rst_n,
  input logic psel,
  input logic penable,
  input logic pwrite,
  input logic [7:0] paddr,
  input logic [31:0] pwdata,
  input logic fuse_rd,
  input logic fuse_burn,
  input logic irq,
  input logic [1:0] cmd,
  input logic [1:0] raw,
  input logic [15:0] key,
  input logic [1:0] st
);
  wire acc = psel & penable & pwrite;
  wire to_cmd = acc && paddr[7:2] == 6'd1;
  wire to_clr = acc && paddr[7:2] == 6'd5;
  wire key_ok = (pwdata == 32'd1 && key == READ_KEY) || (pwdata == 32'd2 && key == PROG_KEY);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_rd && fuse_burn));
  assert_burn_in_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_burn |-> cmd == 2'd2);
  assert_busy_shows_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> (cmd != 2'd0));
  assert_idle_shows_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (cmd == 2'd0));
  assert_key_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (to_cmd && st == 2'd0 && !key_ok) |=> cmd == 2'd0);
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (to_cmd && cmd != 2'd0) |=> (cmd == $past(cmd) || cmd == 2'd0));
  assert_read_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd1 ##1 cmd == 2'd0) |-> raw[0]);
  assert_prog_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd2 ##1 cmd == 2'd0) |-> raw[1]);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (to_clr && pwdata[0] && cmd != 2'd1) |=> !raw[0]);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == 2'd0) |-> !irq);
endmodule

bind fuse_cmd_ctrl fuse_cmd_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .fuse_rd(fuse_rd), .fuse_burn(fuse_burn),
  .irq(irq), .cmd(cmd), .raw(raw), .key(key), .st(st)
);

// File: tb/fuse_cmd_ctrl_test.sv
module fuse_cmd_ctrl_test;
  localparam int WORDS = 4;
  localparam int WIDTH = 16;
  localparam int NBITS = WORDS * WIDTH;
  localparam logic [7:0] KEY = 8'h00, CMD = 8'h04, RAW = 8'h08, ENA = 8'h0C,
                         STS = 8'h10, CLR = 8'h14, TIM = 8'h18, DIV = 8'h1C,
                         SHD = 8'h40, PGM = 8'h80;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic irq, fuse_rd, fuse_burn;
  logic [1:0] fuse_addr;
  logic [3:0] fuse_bit;
  logic [WIDTH-1:0] fuse_rdata;
  logic [WIDTH-1:0] mem [WORDS];

  int checks = 0, fails = 0, cyc = 0;
  int rd_cyc = 0, burn_cyc = 0, pulses = 0, reburn = 0;
  logic pb = 0;
  logic [1:0] pw = 0;
  logic [3:0] pbit = 0;

  always #10 clk = ~clk;

  fuse_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
    .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_rd(fuse_rd),
    .fuse_rdata(fuse_rdata), .fuse_burn(fuse_burn)
  );

  assign fuse_rdata = mem[fuse_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fuse_rd) rd_cyc <= rd_cyc + 1;
    if (fuse_burn) begin
      burn_cyc <= burn_cyc + 1;
      if (!pb || pw != fuse_addr || pbit != fuse_bit) begin
        pulses <= pulses + 1;
        if (mem[fuse_addr][fuse_bit]) reburn <= reburn + 1;
        mem[fuse_addr][fuse_bit] <= 1'b1;
      end
    end
    pb <= fuse_burn;
    pw <= fuse_addr;
    pbit <= fuse_bit;
    if (cyc > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    paddr = a;
    #1;
    d = prdata;
  endtask

  task automatic wait_done(output int n);
    logic [31:0] v;
    n = 0;
    rd(CMD, v);
    while (v != 0 && n < 150000) begin
      @(negedge clk);
      n++;
      rd(CMD, v);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13;
    y ^= y >> 17;
    y ^= y << 5;
    return y;
  endfunction

  function automatic int len1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  logic [WIDTH-1:0] pg_data [WORDS];

  task automatic do_read(input int rl, input string tag);
    logic [31:0] v;
    int n, r0;
    r0 = rd_cyc;
    wr(KEY, 32'h5AA5);
    wr(CMD, 32'd1);
    rd(CMD, v);
    chk({tag, " R2 busy read code"}, v, 1);
    wait_done(n);
    chk({tag, " R3 read duration"}, n, WORDS * rl);
    chk({tag, " R3 read strobe cycles"}, rd_cyc - r0, WORDS * rl);
    for (int w = 0; w < WORDS; w++) begin
      rd(SHD + 8'(4 * w), v);
      chk({tag, " R3 shadow"}, v, {16'd0, mem[w]});
    end
    rd(RAW, v);
    chk({tag, " R8 read done raw"}, v[0], 1);
  endtask

  task automatic do_prog(input int rl, input int bl, input string tag);
    logic [31:0] v;
    logic [WIDTH-1:0] old [WORDS];
    logic [WIDTH-1:0] exp [WORDS];
    logic [WIDTH-1:0] add;
    int n, nb, b0, p0;
    nb = 0;
    for (int w = 0; w < WORDS; w++) old[w] = mem[w];
    for (int w = 0; w < WORDS; w++) begin
      add = old[0][w] ? '0 : (pg_data[w] & ~old[w]);
      nb += $countones(add);
      exp[w] = old[w] | add;
      wr(PGM + 8'(4 * w), {16'd0, pg_data[w]});
    end
    b0 = burn_cyc; p0 = pulses;
    wr(KEY, 32'h5A5A);
    wr(CMD, 32'd2);
    rd(CMD, v);
    chk({tag, " R2 busy program code"}, v, 2);
    wait_done(n);
    chk({tag, " R6 program duration"}, n, 2 * WORDS * rl + NBITS - nb + nb * bl);
    chk({tag, " R6 burn strobe cycles"}, burn_cyc - b0, nb * bl);
    chk({tag, " R4 burn pulses"}, pulses - p0, nb);
    chk({tag, " R4 no reburn"}, reburn, 0);
    for (int w = 0; w < WORDS; w++) begin
      chk({tag, " R5 fuse word"}, {16'd0, mem[w]}, {16'd0, exp[w]});
      rd(SHD + 8'(4 * w), v);
      chk({tag, " R7 shadow after program"}, v, {16'd0, exp[w]});
    end
    rd(RAW, v);
    chk({tag, " R8 program done raw"}, v[1], 1);
  endtask

  initial begin
    logic [31:0] v, seed;
    int n, r0, b0;
    for (int w = 0; w < WORDS; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(CMD, v); chk("R12 cmd reset", v, 0);
    rd(RAW, v); chk("R12 raw reset", v, 0);
    rd(ENA, v); chk("R12 enable reset", v, 0);
    rd(KEY, v); chk("R12 key reset", v, 0);
    rd(TIM, v); chk("R12 timing reset", v, 32'h8050);
    rd(DIV, v); chk("R12 divider reset", v, 32'd100);
    rd(SHD, v); chk("R12 shadow reset", v, 0);
    rd(PGM + 8'd4, v); chk("R12 program data reset", v, 0);
    chk("R12 irq reset", irq, 0);

    wr(TIM, 32'h0002);
    wr(DIV, 32'd1);
    r0 = rd_cyc; b0 = burn_cyc;
    wr(CMD, 32'd1);
    rd(CMD, v); chk("R1 read with zero key", v, 0);
    wr(KEY, 32'h5AA5); wr(CMD, 32'd2);
    rd(CMD, v); chk("R1 program with read key", v, 0);
    wr(KEY, 32'h5A5A); wr(CMD, 32'd1);
    rd(CMD, v); chk("R1 read with program key", v, 0);
    wr(CMD, 32'd3);
    rd(CMD, v); chk("R1 bad opcode", v, 0);
    repeat (10) @(negedge clk);
    chk("R1 no strobes", rd_cyc - r0 + burn_cyc - b0, 0);
    rd(RAW, v); chk("R1 no done event", v, 0);

    for (int w = 0; w < WORDS; w++) mem[w] = 16'(16'h1357 * (w + 1));
    wr(KEY, 32'h5AA5);
    wr(CMD, 32'd1);
    wr(KEY, 32'h5A5A);
    wr(CMD, 32'd2);
    rd(CMD, v); chk("R11 busy keeps read code", v, 1);
    wait_done(n);
    rd(RAW, v); chk("R11 only read completed", v, 1);
    chk("R11 no burn", burn_cyc - b0, 0);
    wr(CLR, 32'd3);
    rd(RAW, v); chk("R9 clear both", v, 0);

    for (int w = 0; w < WORDS; w++) begin mem[w] = '0; pg_data[w] = '0; end
    wr(TIM, 32'h0001);
    pg_data[0] = 16'h0004;
    pg_data[2] = 16'h00F0;
    do_prog(1, 1, "lock same op");
    chk("R5 lock and data together", {16'd0, mem[2]}, 32'h00F0);
    pg_data[0] = 16'h0000;
    pg_data[2] = 16'h0F00;
    do_prog(1, 1, "locked word");
    chk("R5 locked word unchanged", {16'd0, mem[2]}, 32'h00F0);
    wr(CLR, 32'd3);

    wr(TIM, 32'h0001);
    wr(KEY, 32'h5AA5);
    wr(CMD, 32'd1);
    repeat (2) @(negedge clk);
    wr(CLR, 32'd1);
    rd(RAW, v); chk("R9 set beats clear", v[0], 1);
    rd(CMD, v); chk("R2 command cleared", v, 0);
    wr(ENA, 32'd0);
    wr(KEY, 32'h5A5A);
    for (int w = 0; w < WORDS; w++) pg_data[w] = '0;
    do_prog(1, 1, "empty program");
    for (int e = 0; e < 4; e++) begin
      wr(ENA, 32'(e));
      rd(STS, v); chk("R10 status", v, 32'(3 & e));
      chk("R10 irq", irq, (3 & e) != 0);
    end
    wr(CLR, 32'd1);
    rd(RAW, v); chk("R9 clear bit 0 only", v, 2);
    for (int e = 0; e < 4; e++) begin
      wr(ENA, 32'(e));
      rd(STS, v); chk("R10 status after clear", v, 32'(2 & e));
      chk("R10 irq after clear", irq, (2 & e) != 0);
    end
    wr(CLR, 32'd2);
    wr(ENA, 32'd0);

    seed = 32'h1234_5678;
    for (int ri = 0; ri < 3; ri++) begin
      for (int pi = 0; pi < 2; pi++) begin
        for (int di = 0; di < 2; di++) begin
          int rv, pv, dv;
          rv = (ri == 0) ? 0 : (ri == 1 ? 1 : 3);
          pv = pi * 2;
          dv = di * 2 + 1;
          for (int w = 0; w < WORDS; w++) begin
            seed = nxt(seed);
            mem[w] = seed[15:0] & seed[31:16];
            seed = nxt(seed);
            pg_data[w] = seed[15:0];
          end
          wr(TIM, 32'((pv << 8) | rv));
          wr(DIV, 32'(dv));
          do_read(len1(rv), "sweep");
          do_prog(len1(rv), len1(pv) * dv, "sweep");
          wr(CLR, 32'd3);
          rd(RAW, v); chk("R9 sweep clear", v, 0);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule